// File: doc/BRIEF.md
# Timed Write-Strobe Master for an External Slave FIFO

This block drives the write side of an external peripheral's FIFO port, where every write is an asynchronous, active-low strobe rather than a clocked transfer. Words arrive on an internal valid/ready stream. For each accepted word the block drives the data bus. It waits a setup window, pulls the write strobe low for a minimum width, and releases it. It keeps the data on the bus through a hold window. It then waits until the peripheral's full flag can be trusted again before it accepts the next word.

Every window is set in nanoseconds and turned into local-clock cycles by ceiling rounding, with the clock frequency as a parameter. The full flag from the pins is active low and passes through a two-flop synchronizer. The post-write wait covers both the flag's settling time and that synchronizer's latency. When a word carries the stream's last marker, the block follows that word's strobe with an active-low packet-commit pulse on a separate line. That pulse has the same width as the write strobe.

Top module: `fifo_wr_strobe_master`

## Requirements
- R1: While reset is asserted and after it is released with no input word, `fifoWrN` and `fifoPktEndN` are 1. `inReady` is 1 while `fifoFullN` reads 1.
- R2: A word is accepted at a clock edge where `inValid` and `inReady` are both 1. `fifoData` takes that word at the same edge. `fifoWrN` falls exactly SETUP_CYC = ceil(SETUP_NS·f) cycles later, so the data leads the strobe's rising edge by more than SETUP_NS.
- R3: `fifoWrN` stays low for exactly LOW_CYC = ceil(LOW_NS·f) cycles on every write.
- R4: `fifoData` does not change while `fifoWrN` is low, nor within HOLD_NS after `fifoWrN` rises.
- R5: `fifoWrN` stays high for at least ceil(HIGH_NS·f) cycles between two writes.
- R6: `inReady` is 0 from the cycle after an accept until the write sequence has ended. Accepted words reach the bus, one strobe per word, in stream order.
- R7: After a strobe's rising edge, `inReady` stays 0 for at least FLAG_CYC + 2 cycles, where FLAG_CYC = ceil(FLAG_NS·f). A change on `fifoFullN` reaches `inReady` two clock edges later.
- R8: A word accepted with `inLast` = 1 is followed by one `fifoPktEndN` low pulse of exactly LOW_CYC cycles. The pulse starts exactly HOLD_CYC = ceil(HOLD_NS·f) cycles after that word's strobe rises, and never overlaps a write strobe. A word with `inLast` = 0 produces no such pulse.
- R9: While the synchronized `fifoFullN` is 0, no word is accepted and no write strobe is issued. Writing resumes once the flag returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, frequency CLK_MHZ |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Stream word available |
| inReady | output | 1 | Block takes the word at this edge |
| inData | input | DATA_W | Stream word |
| inLast | input | 1 | Word closes a packet |
| fifoFullN | input | 1 | Peripheral full flag, active low, asynchronous |
| fifoData | output | DATA_W | Data bus to the peripheral |
| fifoWrN | output | 1 | Active-low asynchronous write strobe |
| fifoPktEndN | output | 1 | Active-low packet-commit pulse |

## Verification
The strobe's falling edge is due exactly SETUP_CYC cycles after the accepting edge, and its rising edge LOW_CYC cycles after that. A packet-commit pulse starts HOLD_CYC cycles after the rise and lasts LOW_CYC cycles. A flag change shows at `inReady` two edges after the pin moves. The bench time-stamps every pin edge, compares the exact delays against these cycle counts times the clock period, and bounds the high width, the hold time and the flag wait from below. Port values are sampled on the falling clock edge, one or two cycles after the stimulus as each result requires.

// File: rtl/fifo_wr_pkg.sv
`timescale 1ns/1ps
package fifo_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HOLD, ST_PEND, ST_WAIT
  } wrState_t;

  // strobes from the sequencer to the pin registers
  typedef struct packed {
    logic loadData;
    logic wrLow;
    logic wrHigh;
    logic peLow;
    logic peHigh;
  } wrCtl_t;

  function automatic int nsToCycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fifo_wr_sync.sv
`timescale 1ns/1ps
module fifo_wr_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stage;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage <= RESET_VAL;
        else       stage <= asyncIn;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage <= {STAGES{RESET_VAL}};
        else       stage <= {stage[STAGES-2:0], asyncIn};
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/1ps
module fifo_wr_ctrl
  import fifo_wr_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int LOW_CYC   = 5,
  parameter int HOLD_CYC  = 1,
  parameter int WAIT_CYC  = 9,
  parameter int CNT_W     = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   notFull,
  output logic   inReady,
  output wrCtl_t ctl
);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LD  = CNT_W'(WAIT_CYC - 1);

  wrState_t         state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             lastPend;
  logic             cntDone;

  assign cntDone = (cnt == '0);
  assign inReady = (state == ST_IDLE) && notFull;

  always_comb begin
    nxtState = state;
    nxtCnt   = cntDone ? cnt : cnt - 1'b1;
    ctl      = '0;
    unique case (state)
      ST_IDLE: if (inValid && inReady) begin
        ctl.loadData = 1'b1;
        nxtState     = ST_SETUP;
        nxtCnt       = SETUP_LD;
      end
      ST_SETUP: if (cntDone) begin
        ctl.wrLow = 1'b1;
        nxtState  = ST_LOW;
        nxtCnt    = LOW_LD;
      end
      ST_LOW: if (cntDone) begin
        ctl.wrHigh = 1'b1;
        nxtState   = ST_HOLD;
        nxtCnt     = HOLD_LD;
      end
      ST_HOLD: if (cntDone) begin
        if (lastPend) begin
          ctl.peLow = 1'b1;
          nxtState  = ST_PEND;
          nxtCnt    = LOW_LD;
        end else begin
          nxtState = ST_WAIT;
          nxtCnt   = WAIT_LD;
        end
      end
      ST_PEND: if (cntDone) begin
        ctl.peHigh = 1'b1;
        nxtState   = ST_WAIT;
        nxtCnt     = WAIT_LD;
      end
      ST_WAIT: if (cntDone) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastPend <= 1'b0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
      if (ctl.loadData)   lastPend <= inLast;
      else if (ctl.peLow) lastPend <= 1'b0;
    end
  end

  // an accept closes the ready window for the following cycle
  assert_one_word_per_seq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // every strobe fall is preceded by a completed setup phase
  assert_fall_after_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrLow |-> (state == ST_SETUP) && cntDone);
endmodule

// File: rtl/fifo_wr_datapath.sv
`timescale 1ns/1ps
module fifo_wr_datapath
  import fifo_wr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LOW_CYC = 5,
  parameter int RUN_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoWrN,
  output logic              fifoPktEndN
);
  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoData    <= '0;
      fifoWrN     <= 1'b1;
      fifoPktEndN <= 1'b1;
      lowRun      <= '0;
    end else begin
      if (ctl.loadData) fifoData <= inData;
      if (ctl.wrLow)       fifoWrN <= 1'b0;
      else if (ctl.wrHigh) fifoWrN <= 1'b1;
      if (ctl.peLow)       fifoPktEndN <= 1'b0;
      else if (ctl.peHigh) fifoPktEndN <= 1'b1;
      if (ctl.wrLow)       lowRun <= '0;
      else if (!fifoWrN)   lowRun <= lowRun + 1'b1;
    end
  end

  assert_data_stable_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoWrN || $rose(fifoWrN)) |-> $stable(fifoData));

  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoWrN) |-> (lowRun == RUN_W'(LOW_CYC)));

  assert_pktend_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!fifoWrN && !fifoPktEndN));
endmodule

// File: rtl/fifo_wr_strobe_master.sv
`timescale 1ns/1ps
module fifo_wr_strobe_master
  import fifo_wr_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int DATA_W      = 16,
  parameter int SETUP_NS    = 10,
  parameter int LOW_NS      = 50,
  parameter int HIGH_NS     = 70,
  parameter int HOLD_NS     = 10,
  parameter int FLAG_NS     = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              fifoFullN,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoWrN,
  output logic              fifoPktEndN
);
  localparam int SETUP_CYC = maxInt(1, nsToCycles(SETUP_NS, CLK_MHZ));
  localparam int LOW_CYC   = maxInt(1, nsToCycles(LOW_NS, CLK_MHZ));
  localparam int HIGH_CYC  = nsToCycles(HIGH_NS, CLK_MHZ);
  localparam int HOLD_CYC  = maxInt(1, nsToCycles(HOLD_NS, CLK_MHZ));
  localparam int FLAG_CYC  = nsToCycles(FLAG_NS, CLK_MHZ);
  // flag window counted from the strobe rise, synchronizer included;
  // also stretched so that the high width is met on back-to-back words
  localparam int WAIT_CYC  = maxInt(1, maxInt(FLAG_CYC + SYNC_STAGES - HOLD_CYC,
                                               HIGH_CYC - 1 - SETUP_CYC - HOLD_CYC));
  localparam int MAX_LD    = maxInt(maxInt(SETUP_CYC, LOW_CYC), maxInt(HOLD_CYC, WAIT_CYC));
  localparam int CNT_W     = $clog2(MAX_LD + 1);
  localparam int RUN_W     = $clog2(LOW_CYC + 2);

  wrCtl_t ctl;
  logic   notFull;

  fifo_wr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(fifoFullN), .syncOut(notFull));

  fifo_wr_ctrl #(
    .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC),
    .WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .notFull(notFull), .inReady(inReady), .ctl(ctl));

  fifo_wr_datapath #(.DATA_W(DATA_W), .LOW_CYC(LOW_CYC), .RUN_W(RUN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .fifoData(fifoData), .fifoWrN(fifoWrN), .fifoPktEndN(fifoPktEndN));

  // synchronized full flag and sequencer must agree: no accept while full
  assert_full_no_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    !notFull |-> !(inValid && inReady));

  // a strobe fall is always the second step of an accepted word
  assert_strobe_needs_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoWrN) |-> !inReady);
endmodule

// File: tb/fifo_wr_strobe_master_tb.sv
`timescale 1ns/1ps
module fifo_wr_strobe_master_tb_top;
  localparam int    MHZ   = 250;
  localparam realtime TCK = 4.0;
  localparam int    DW    = 16;
  localparam int    NVEC  = 8;

  function automatic int cyc(input int ns);
    return (ns * MHZ + 999) / 1000;
  endfunction
  localparam int S_C = cyc(10);
  localparam int L_C = cyc(50);
  localparam int H_C = cyc(10);
  localparam int F_C = cyc(70);
  localparam int HI_C = cyc(70);

  // {last, data}
  localparam logic [DW:0] VEC [NVEC] = '{
    17'h0_1234, 17'h0_ABCD, 17'h1_00FF, 17'h1_8001,
    17'h0_5A5A, 17'h0_A5A5, 17'h0_0000, 17'h1_FFFF };

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inLast = 1'b0, fifoFullN = 1'b1;
  logic inReady, fifoWrN, fifoPktEndN;
  logic [DW-1:0] inData = '0, fifoData;

  int checks = 0, errors = 0;
  bit armed = 0;
  int capLimit = 1000, cnt = 0, pushCount = 0, sendIdx = 0, pushIdx = 0;
  logic [DW-1:0] expData [32];
  bit expLast [32];
  bit pendingLast = 0, haveRise = 0;
  logic [DW-1:0] lastPushed = '0;
  realtime tAccept = 0, tFall = 0, tRise = 0, tData = 0, tPeFall = 0;

  always #2 clk = ~clk;

  fifo_wr_strobe_master #(.CLK_MHZ(MHZ), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .fifoFullN(fifoFullN),
    .fifoData(fifoData), .fifoWrN(fifoWrN), .fifoPktEndN(fifoPktEndN));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---- timestamped peripheral model ----
  always @(posedge clk) if (armed && inValid && inReady) tAccept = $realtime;

  always @(fifoData) if (armed) begin
    check(fifoWrN === 1'b1, "R4", "data moved while strobe low", 0, 1);
    if (haveRise)
      check($realtime - tRise >= 10.0, "R4", "hold after rise ps",
            longint'(($realtime - tRise) * 1000), 10000);
    tData = $realtime;
  end

  always @(negedge fifoWrN) if (armed) begin
    check($realtime - tAccept == S_C * TCK, "R2", "accept to fall ps",
          longint'(($realtime - tAccept) * 1000), longint'(S_C * TCK * 1000));
    if (haveRise)
      check($realtime - tRise >= HI_C * TCK, "R5", "high width ps",
            longint'(($realtime - tRise) * 1000), longint'(HI_C * TCK * 1000));
    tFall = $realtime;
  end

  always @(posedge fifoWrN) if (armed) begin
    check($realtime - tFall == L_C * TCK, "R3", "low width ps",
          longint'(($realtime - tFall) * 1000), longint'(L_C * TCK * 1000));
    check($realtime - tData >= 10.0, "R2", "setup before rise ps",
          longint'(($realtime - tData) * 1000), 10000);
    check(cnt < capLimit, "R9", "write into full fifo", cnt, capLimit - 1);
    check(!pendingLast, "R8", "missing packet end before next word", 1, 0);
    check(fifoData == expData[pushIdx], "R6", "word order",
          fifoData, expData[pushIdx]);
    pendingLast = expLast[pushIdx];
    lastPushed = fifoData;
    pushIdx++; pushCount++; cnt++;
    tRise = $realtime; haveRise = 1;
    #70;
    if (cnt >= capLimit) fifoFullN = 1'b0;
  end

  always @(negedge fifoPktEndN) if (armed) begin
    check(pendingLast, "R8", "packet end without last word", 0, 1);
    check($realtime - tRise == H_C * TCK, "R8", "rise to packet end ps",
          longint'(($realtime - tRise) * 1000), longint'(H_C * TCK * 1000));
    check(fifoWrN === 1'b1, "R8", "overlap with strobe", fifoWrN, 1);
    tPeFall = $realtime;
  end

  always @(posedge fifoPktEndN) if (armed) begin
    check($realtime - tPeFall == L_C * TCK, "R8", "packet end width ps",
          longint'(($realtime - tPeFall) * 1000), longint'(L_C * TCK * 1000));
    pendingLast = 0;
  end

  always @(posedge inReady) if (armed && haveRise && fifoFullN)
    check($realtime - tRise >= (F_C + 2) * TCK, "R7", "flag wait ps",
          longint'(($realtime - tRise) * 1000), longint'((F_C + 2) * TCK * 1000));

  task automatic sendWord(input logic [DW-1:0] d, input bit l);
    expData[sendIdx] = d; expLast[sendIdx] = l; sendIdx++;
    @(negedge clk);
    inValid = 1'b1; inData = d; inLast = l;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R6", "ready after accept", inReady, 0);
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int held;
    repeat (4) @(negedge clk);
    check(fifoWrN == 1'b1, "R1", "strobe in reset", fifoWrN, 1);
    check(fifoPktEndN == 1'b1, "R1", "packet end in reset", fifoPktEndN, 1);
    rstN = 1'b1;
    armed = 1;
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R1", "ready after reset", inReady, 1);
    check(fifoWrN == 1'b1 && pushCount == 0, "R1", "idle without word", pushCount, 0);

    // table walk: back-to-back words, mixed packet markers
    for (int i = 0; i < NVEC; i++) sendWord(VEC[i][DW-1:0], VEC[i][DW]);
    repeat (60) @(negedge clk);
    check(pushCount == NVEC, "R6", "words written", pushCount, NVEC);
    check(!pendingLast, "R8", "final packet committed", pendingLast, 0);

    // full flag gating
    capLimit = cnt + 2;
    sendWord(16'h1111, 1'b0);
    sendWord(16'h2222, 1'b0);
    repeat (30) @(negedge clk);
    held = pushCount;
    expData[sendIdx] = 16'h3333; expLast[sendIdx] = 1'b1; sendIdx++;
    inValid = 1'b1; inData = 16'h3333; inLast = 1'b1;
    repeat (60) @(negedge clk);
    check(pushCount == held, "R9", "write while full", pushCount, held);
    check(inReady == 1'b0, "R9", "ready while full", inReady, 0);
    check(fifoWrN == 1'b1, "R9", "strobe while full", fifoWrN, 1);
    cnt = 0; capLimit = 1000; fifoFullN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0, "R7", "ready one edge after release", inReady, 0);
    @(negedge clk);
    check(inReady == 1'b1, "R7", "ready two edges after release", inReady, 1);
    @(negedge clk);
    inValid = 1'b0;
    repeat (60) @(negedge clk);
    check(pushCount == held + 1, "R9", "resumed after release", pushCount, held + 1);
    check(lastPushed == 16'h3333, "R9", "resumed word", lastPushed, 16'h3333);
    check(fifoPktEndN == 1'b1 && !pendingLast, "R8", "packet end after resume",
          pendingLast, 0);
    summary();
  end
endmodule